// File: doc/BRIEF.md
# Four-Slot Transfer Byte Queue

This block is a small first-in first-out byte store placed between a byte-wide register port and a serial-bus master engine. Software queues outgoing bytes by writing a single data register and drains received bytes by reading that same register. On every read, the oldest slot is returned and the remaining slots move down by one position. Once the engine has received bytes, it replaces the whole queue in one cycle through a bulk-load port. It also sees all four slots in parallel, so it can fetch the bytes it is to transmit.

The queue keeps a fill count from 0 to 4 and two sticky status bits, "holds data" and "full". A flush command, carried by a bit of the mode-control register, empties the queue. Reading an empty queue returns all ones. A write to a full queue is discarded. The register port presents at most one access per cycle. If a read and a write do arrive in the same cycle, the read is taken and the write is discarded.

Top module: `bq_top`

## Requirements
- R1: A data write when the fill count is below 4 stores the byte at slot index equal to the old count and raises the count by one, so bytes are read back in the order they were written.
- R2: A data write when the count is 4 is discarded: count, slots and flags are unchanged.
- R3: A data write that brings the count to 4 sets `fullFlag`; a data write that brings the count to 1 sets `notEmptyFlag`.
- R4: A data read when the count is 0 returns 0xFF on `regRdData` and changes no state.
- R5: A data read when the count is nonzero returns slot 0 on `regRdData` in the same cycle, moves every slot down one position, and lowers the count by one.
- R6: A data read taken at count 4 clears `fullFlag`; a data read taken at count 1 clears `notEmptyFlag`.
- R7: A mode-control write with bit 6 set makes the count 0, zeroes all slots and clears both flags. A mode-control write with bit 6 clear has no effect on the queue.
- R8: After reset, the count is 0, all slots are zero and both flags are clear.
- R9: When requests coincide in one cycle, they are served in the order flush, then bulk load, then read, then write; every request of lower rank in that cycle is dropped.
- R10: A bulk load sets slot i to `loadData[8i+7:8i]` and the count to `loadCount` (0 to 4). It sets `notEmptyFlag` when the count is at least 1 and sets `fullFlag` when the count is 4. It never clears a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Data register write strobe (push) |
| regRdEn | input | 1 | Data register read strobe (pop) |
| regWrData | input | 8 | Byte to push |
| regRdData | output | 8 | Slot 0, or 0xFF when empty; valid in the strobe cycle |
| modeWrEn | input | 1 | Mode-control register write strobe |
| modeWrData | input | 8 | Mode-control byte; bit 6 requests a flush |
| loadEn | input | 1 | Bulk-load strobe from the transfer engine |
| loadCount | input | 3 | Number of valid bytes in the bulk load (0 to 4) |
| loadData | input | 32 | Bulk-load bytes, slot i in bits 8i+7:8i |
| fillCount | output | 3 | Number of bytes held |
| fullFlag | output | 1 | Sticky full status bit |
| notEmptyFlag | output | 1 | Sticky holds-data status bit |
| bufData | output | 32 | All slots in parallel, slot i in bits 8i+7:8i |

## Verification
Suppose the fill count drifts from the true number of queued bytes. The error appears at `fillCount` on the next edge. It also surfaces one read later, either as an early 0xFF or as a stale byte on `regRdData`. A slot written at the wrong index, or a broken shift, shows as a byte out of order on the first read that reaches it. A flag set or cleared on the wrong transition is visible at the status outputs in the cycle after the access. It stays wrong until a later access corrects it, because both flags are sticky.

// File: rtl/bq_pkg.sv
package bq_pkg;

  // Strobes issued by the control path to the slot datapath, one per cycle at most.
  typedef struct packed {
    logic clear;
    logic load;
    logic pop;
    logic push;
  } bqStrobe_t;

endpackage

// File: rtl/bq_ctrl.sv
module bq_ctrl
  import bq_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 8,
  parameter int FLUSH_BIT = 6,
  localparam int CNTW     = $clog2(DEPTH + 1),
  localparam int SLOTW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             modeWrEn,
  input  logic [WIDTH-1:0] modeWrData,
  input  logic             loadEn,
  input  logic [CNTW-1:0]  loadCount,
  output bqStrobe_t        strobe,
  output logic [SLOTW-1:0] pushSlot,
  output logic [CNTW-1:0]  fillCount,
  output logic             fullFlag,
  output logic             notEmptyFlag
);

  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(DEPTH - 1);

  logic [CNTW-1:0] countQ;
  logic            fullQ;
  logic            nonEmptyQ;
  logic            flushReq;
  logic            isEmpty;
  logic            isFull;
  logic [CNTW-1:0] loadClamped;

  assign flushReq    = modeWrEn & modeWrData[FLUSH_BIT];
  assign isEmpty     = (countQ == '0);
  assign isFull      = (countQ == CNT_FULL);
  assign loadClamped = (loadCount > CNT_FULL) ? CNT_FULL : loadCount;

  // Fixed precedence: flush, bulk load, read, write.
  always_comb begin
    strobe.clear = flushReq;
    strobe.load  = loadEn & ~flushReq;
    strobe.pop   = regRdEn & ~loadEn & ~flushReq & ~isEmpty;
    strobe.push  = regWrEn & ~regRdEn & ~loadEn & ~flushReq & ~isFull;
  end

  assign pushSlot = SLOTW'(countQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      fullQ     <= 1'b0;
      nonEmptyQ <= 1'b0;
    end else if (strobe.clear) begin
      countQ    <= '0;
      fullQ     <= 1'b0;
      nonEmptyQ <= 1'b0;
    end else if (strobe.load) begin
      countQ <= loadClamped;
      if (loadClamped != '0)      nonEmptyQ <= 1'b1;
      if (loadClamped == CNT_FULL) fullQ    <= 1'b1;
    end else if (strobe.pop) begin
      countQ <= countQ - 1'b1;
      if (countQ == CNT_FULL)   fullQ     <= 1'b0;
      if (countQ == CNTW'(1))   nonEmptyQ <= 1'b0;
    end else if (strobe.push) begin
      countQ <= countQ + 1'b1;
      if (countQ == CNT_LAST) fullQ     <= 1'b1;
      if (countQ == '0)       nonEmptyQ <= 1'b1;
    end
  end

  assign fillCount    = countQ;
  assign fullFlag     = fullQ;
  assign notEmptyFlag = nonEmptyQ;

endmodule

// File: rtl/bq_data.sv
module bq_data
  import bq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WIDTH  = 8,
  localparam int SLOTW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BUSW  = DEPTH * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  bqStrobe_t        strobe,
  input  logic [SLOTW-1:0] pushSlot,
  input  logic [WIDTH-1:0] wrData,
  input  logic [BUSW-1:0]  loadData,
  input  logic             isEmpty,
  output logic [WIDTH-1:0] rdData,
  output logic [BUSW-1:0]  bufData
);

  logic [WIDTH-1:0] slotQ [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [WIDTH-1:0] fromAbove;

    if (g == DEPTH - 1) begin : gTop
      assign fromAbove = slotQ[g];
    end else begin : gMid
      assign fromAbove = slotQ[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clear) begin
        slotQ[g] <= '0;
      end else if (strobe.load) begin
        slotQ[g] <= loadData[g*WIDTH +: WIDTH];
      end else if (strobe.pop) begin
        slotQ[g] <= fromAbove;
      end else if (strobe.push && pushSlot == SLOTW'(g)) begin
        slotQ[g] <= wrData;
      end
    end

    assign bufData[g*WIDTH +: WIDTH] = slotQ[g];
  end

  assign rdData = isEmpty ? {WIDTH{1'b1}} : slotQ[0];

endmodule

// File: rtl/bq_top.sv
module bq_top
  import bq_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 8,
  parameter int FLUSH_BIT = 6,
  localparam int CNTW     = $clog2(DEPTH + 1),
  localparam int SLOTW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BUSW     = DEPTH * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic             modeWrEn,
  input  logic [WIDTH-1:0] modeWrData,
  input  logic             loadEn,
  input  logic [CNTW-1:0]  loadCount,
  input  logic [BUSW-1:0]  loadData,
  output logic [CNTW-1:0]  fillCount,
  output logic             fullFlag,
  output logic             notEmptyFlag,
  output logic [BUSW-1:0]  bufData
);

  bqStrobe_t        strobe;
  logic [SLOTW-1:0] pushSlot;

  bq_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FLUSH_BIT(FLUSH_BIT)) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .modeWrEn     (modeWrEn),
    .modeWrData   (modeWrData),
    .loadEn       (loadEn),
    .loadCount    (loadCount),
    .strobe       (strobe),
    .pushSlot     (pushSlot),
    .fillCount    (fillCount),
    .fullFlag     (fullFlag),
    .notEmptyFlag (notEmptyFlag)
  );

  bq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushSlot (pushSlot),
    .wrData   (regWrData),
    .loadData (loadData),
    .isEmpty  (fillCount == '0),
    .rdData   (regRdData),
    .bufData  (bufData)
  );

endmodule

// File: rtl/bq_chk.sv
module bq_chk #(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 8,
  parameter int FLUSH_BIT = 6,
  localparam int CNTW     = $clog2(DEPTH + 1),
  localparam int BUSW     = DEPTH * WIDTH
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [WIDTH-1:0] regRdData,
  input logic             modeWrEn,
  input logic [WIDTH-1:0] modeWrData,
  input logic             loadEn,
  input logic [CNTW-1:0]  fillCount,
  input logic             fullFlag,
  input logic             notEmptyFlag,
  input logic [BUSW-1:0]  bufData
);

  logic flushReq;
  logic soloWrite;
  logic soloRead;

  assign flushReq  = modeWrEn & modeWrData[FLUSH_BIT];
  assign soloWrite = regWrEn & ~regRdEn & ~loadEn & ~flushReq;
  assign soloRead  = regRdEn & ~loadEn & ~flushReq;

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    soloWrite && fillCount < CNTW'(DEPTH) |=> fillCount == CNTW'($past(fillCount) + 1'b1)); // R1

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    soloWrite && fillCount == CNTW'(DEPTH) |=> fillCount == CNTW'(DEPTH) && $stable(bufData)); // R2

  AST_FULL_ON_FILL: assert property (@(posedge clk) disable iff (!rstN)
    soloWrite && fillCount == CNTW'(DEPTH - 1) |=> fullFlag); // R3

  AST_EMPTY_READ_ONES: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && fillCount == '0 |-> regRdData == {WIDTH{1'b1}}); // R4

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    soloRead && fillCount == '0 |=> fillCount == '0 && $stable(bufData)); // R4

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    soloRead && fillCount != '0 |=> fillCount == CNTW'($past(fillCount) - 1'b1)); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> fillCount == '0 && !fullFlag && !notEmptyFlag && bufData == '0); // R7

endmodule

bind bq_top bq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FLUSH_BIT(FLUSH_BIT)) chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regRdEn      (regRdEn),
  .regRdData    (regRdData),
  .modeWrEn     (modeWrEn),
  .modeWrData   (modeWrData),
  .loadEn       (loadEn),
  .fillCount    (fillCount),
  .fullFlag     (fullFlag),
  .notEmptyFlag (notEmptyFlag),
  .bufData      (bufData)
);

// File: tb/bq_top_test.sv
`timescale 1ns/1ps
module bq_top_test;

  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam int CNTW  = 3;
  localparam int BUSW  = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic            regRdEn = 1'b0;
  logic [7:0]      regWrData = '0;
  logic [7:0]      regRdData;
  logic            modeWrEn = 1'b0;
  logic [7:0]      modeWrData = '0;
  logic            loadEn = 1'b0;
  logic [CNTW-1:0] loadCount = '0;
  logic [BUSW-1:0] loadData = '0;
  logic [CNTW-1:0] fillCount;
  logic            fullFlag;
  logic            notEmptyFlag;
  logic [BUSW-1:0] bufData;

  always #2 clk = ~clk;

  bq_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .modeWrEn(modeWrEn),
    .modeWrData(modeWrData), .loadEn(loadEn), .loadCount(loadCount),
    .loadData(loadData), .fillCount(fillCount), .fullFlag(fullFlag),
    .notEmptyFlag(notEmptyFlag), .bufData(bufData)
  );

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 0;

  // Reference model of the queue contents and sticky flags.
  logic [7:0] modelQ[$];
  bit mFull = 0;
  bit mNe = 0;

  // Scoreboard of expected read bytes, filled by the driver.
  logic [7:0] expQ[$];
  string tagQ[$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    check({req, " count"}, 64'(fillCount), 64'(modelQ.size()));
    check({req, " full"}, 64'(fullFlag), 64'(mFull));
    check({req, " notEmpty"}, 64'(notEmptyFlag), 64'(mNe));
  endtask

  // Monitor: compares each read against the next scoreboard entry.
  always @(negedge clk) begin
    #1;
    if (regRdEn === 1'b1) begin
      if (expQ.size() == 0) begin
        check("R5 unexpected read", 64'(regRdData), 64'hX);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, 64'(regRdData), 64'(e));
      end
    end
  end

  function automatic void modelPush(logic [7:0] b);
    if (modelQ.size() < DEPTH) begin
      modelQ.push_back(b);
      if (modelQ.size() == DEPTH) mFull = 1;
      if (modelQ.size() == 1) mNe = 1;
    end
  endfunction

  function automatic void modelPop(string tag);
    if (modelQ.size() == 0) begin
      expQ.push_back(8'hFF);
    end else begin
      expQ.push_back(modelQ[0]);
    end
    tagQ.push_back(tag);
    if (modelQ.size() != 0) begin
      if (modelQ.size() == DEPTH) mFull = 0;
      if (modelQ.size() == 1) mNe = 0;
      void'(modelQ.pop_front());
    end
  endfunction

  function automatic void modelLoad(int cnt, logic [BUSW-1:0] d);
    modelQ.delete();
    for (int i = 0; i < cnt; i++) modelQ.push_back(d[i*8 +: 8]);
    if (cnt > 0) mNe = 1;
    if (cnt == DEPTH) mFull = 1;
  endfunction

  function automatic void modelFlush();
    modelQ.delete();
    mFull = 0;
    mNe = 0;
  endfunction

  task automatic pushByte(logic [7:0] b);
    @(negedge clk);
    regWrEn = 1; regWrData = b;
    modelPush(b);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic popByte(string tag);
    @(negedge clk);
    modelPop(tag);
    regRdEn = 1;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic modeWrite(logic [7:0] v);
    @(negedge clk);
    modeWrEn = 1; modeWrData = v;
    if (v[6]) modelFlush();
    @(negedge clk);
    modeWrEn = 0;
  endtask

  task automatic bulkLoad(int cnt, logic [BUSW-1:0] d);
    @(negedge clk);
    loadEn = 1; loadCount = CNTW'(cnt); loadData = d;
    modelLoad(cnt, d);
    @(negedge clk);
    loadEn = 0;
  endtask

  initial begin
    #80000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    if (!summaryDone) $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8: reset state
    checkState("R8");
    check("R8 slots", 64'(bufData), 64'h0);

    // R4: read when empty returns ones and leaves state alone
    popByte("R4 empty read");
    checkState("R4");

    // R1, R3: fill in order
    pushByte(8'h11); checkState("R3 first push");
    pushByte(8'h22);
    pushByte(8'h33); checkState("R1 three pushes");
    pushByte(8'h44); checkState("R3 full");
    check("R1 slot layout", 64'(bufData), 64'h44332211);

    // R2: write to a full queue is dropped
    pushByte(8'h55); checkState("R2 dropped write");
    check("R2 slots kept", 64'(bufData), 64'h44332211);

    // R5, R6: drain in order
    popByte("R5 pop1"); checkState("R6 full cleared");
    check("R5 shift", 64'(bufData[23:0]), 64'h443322);
    popByte("R5 pop2");
    popByte("R5 pop3");
    popByte("R5 pop4"); checkState("R6 notEmpty cleared");
    popByte("R4 read after drain"); checkState("R4 after drain");

    // R9: read beats write in the same cycle
    pushByte(8'hA1);
    pushByte(8'hA2);
    @(negedge clk);
    modelPop("R9 read wins");
    regRdEn = 1; regWrEn = 1; regWrData = 8'hEE;
    @(negedge clk);
    regRdEn = 0; regWrEn = 0;
    checkState("R9 write dropped");
    popByte("R9 remaining");
    popByte("R9 empty after");

    // R7: mode write without flush bit has no effect, with it empties
    pushByte(8'h5A);
    pushByte(8'hC3);
    modeWrite(8'hBF); checkState("R7 no flush");
    check("R7 slots kept", 64'(bufData[15:0]), 64'hC35A);
    modeWrite(8'h40); checkState("R7 flush");
    check("R7 slots zeroed", 64'(bufData), 64'h0);

    // R9: flush beats a simultaneous write and load
    pushByte(8'h77);
    @(negedge clk);
    modeWrEn = 1; modeWrData = 8'h40; regWrEn = 1; regWrData = 8'h99;
    loadEn = 1; loadCount = 3'd4; loadData = 32'hDEADBEEF;
    modelFlush();
    @(negedge clk);
    modeWrEn = 0; regWrEn = 0; loadEn = 0;
    checkState("R9 flush wins");
    check("R9 flush slots", 64'(bufData), 64'h0);

    // R10: bulk load of three bytes
    bulkLoad(3, 32'h00C0B0A0); checkState("R10 load3");
    check("R10 slots", 64'(bufData), 64'h00C0B0A0);
    popByte("R10 pop a");
    popByte("R10 pop b");
    popByte("R10 pop c"); checkState("R10 drained");

    // R10: full load, then a shorter load keeps the sticky full flag
    bulkLoad(4, 32'h04030201); checkState("R10 load4");
    bulkLoad(2, 32'h00001211); checkState("R10 sticky full");

    // R9: load beats a simultaneous read; head shown but not removed
    @(negedge clk);
    expQ.push_back(modelQ[0]); tagQ.push_back("R9 load beats read");
    regRdEn = 1; loadEn = 1; loadCount = 3'd1; loadData = 32'h000000F1;
    modelLoad(1, 32'h000000F1);
    @(negedge clk);
    regRdEn = 0; loadEn = 0;
    checkState("R9 load wins");
    popByte("R10 single byte");
    checkState("R10 after single pop");

    // R10: load of zero bytes leaves flags alone
    bulkLoad(0, 32'hFFFFFFFF); checkState("R10 empty load");
    popByte("R4 empty after zero load");

    repeat (2) @(negedge clk);
    check("scoreboard drained", 64'(expQ.size()), 64'h0);
    summaryDone = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule